// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 52-bit physical address. It reads a four-level radix tree of translation entries from physical memory, one 64-bit entry per level. Each table is one 4 KB page of 512 entries. The root table's physical base comes from an input. Every pointer read out of an entry is already physical, so the walker never translates its own accesses.

At each level the walker checks the entry's present bit and the user and write permissions against the access. It stops early at a large-page leaf, covering 1 GB at level 2 or 2 MB at level 3. It writes the accessed flag back into each entry that passes its checks, and the dirty flag into the leaf on a write. A request is accepted only while the walker is idle. The result comes back as a one-cycle done pulse carrying the physical address, a 2-bit fault cause and the level at which the walk ended.

The controller is a five-state machine:
- **IDLE**: waits for a request.
  - A canonical address moves to **FETCH** at level 1.
  - A non-canonical address goes straight to **FINISH**.
- **FETCH**: holds a read until it is acknowledged, then moves to **CHECK**.
- **CHECK**: evaluates the entry.
  - A fault goes to **FINISH**.
  - A needed flag update goes to **UPDATE**.
  - A leaf with no update goes to **FINISH**.
  - Anything else returns to **FETCH** one level down.
- **UPDATE**: holds a write until it is acknowledged, then goes to **FINISH** for a leaf or **FETCH** otherwise.
- **FINISH**: raises done for one cycle and returns to **IDLE**.

Top module: `ptw_walker`

## Requirements
- R1: An address is canonical only when bits 63..48 all equal bit 47. A non-canonical request gives done on the cycle after acceptance with fault code 1 and level 0, and makes no memory access.
- R2: The level-1 entry is read at root_base[51:12] concatenated with vaddr[47:39] and three zero bits. Levels 2, 3 and 4 use vaddr[38:30], [29:21] and [20:12] on the base taken from bits 51:12 of the previous entry. A full 4 KB walk issues exactly one read per level.
- R3: If entry bit 0 (present) is clear at any level, the walk ends with fault code 2, and done_level reports that level (1 to 4).
- R4: The walk ends with fault code 3 at the current level in two cases. The first is a user access (req_user=1) meeting an entry whose bit 2 is clear. The second is a write (req_write=1) meeting an entry whose bit 1 is clear, in either mode. A supervisor read ignores both bits.
- R5: A level-4 entry is always a leaf. The physical address is entry bits 51:12 followed by vaddr[11:0], with fault code 0 and level 4.
- R6: Bit 7 of an entry marks a large-page leaf in two places. At level 2 it maps a 1 GB page (entry bits 51:30, vaddr[29:0]). At level 3 it maps a 2 MB page (entry bits 51:21, vaddr[20:0]). Bit 7 has no effect at levels 1 and 4.
- R7: Each entry that passes its present and permission checks is written back to its own address with bit 5 (accessed) set. No write is issued when the entry already holds every flag it would receive. An entry that fails its checks is not written.
- R8: On a write access, the leaf entry also gets bit 6 (dirty) set. Non-leaf entries, and all entries on a read, keep bit 6 unchanged.
- R9: At most one memory transaction is outstanding. mem_req, mem_we, mem_addr and mem_wdata stay stable from the cycle mem_req rises until the cycle mem_ack is seen.
- R10: busy is high from the cycle after acceptance through the single-cycle done pulse. done_paddr is zero whenever the fault code is non-zero.
- R11: A request raised while busy is ignored. It changes neither the result of the walk in progress nor produces any extra done pulse.
- R12: During and after reset the walker is idle, with busy, done and mem_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| root_base | input | PA_BITS (52) | Physical base of the level-1 table; low 12 bits ignored |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| done_paddr | output | PA_BITS (52) | Translated physical address, zero on a fault |
| done_fault | output | 2 | 0 none, 1 non-canonical, 2 not present, 3 permission |
| done_level | output | LVL_W (3) | Level at which the walk ended, 0 for non-canonical |
| mem_req | output | 1 | Memory transaction request, held until acknowledged |
| mem_we | output | 1 | Transaction is an entry write-back |
| mem_addr | output | PA_BITS (52) | Physical entry address |
| mem_wdata | output | 64 | Entry value to write |
| mem_ack | input | 1 | One-cycle completion of the current transaction |
| mem_rdata | input | 64 | Read entry, valid with mem_ack |

## Verification
Each address class is tried in turn:
- **Non-canonical addresses**: both sign polarities, to separate the canonical filter from the walk.
- **4 KB, 2 MB and 1 GB leaves**: to check which address bits come from the entry and which come from the offset.
- **Bit 7 at levels 1 and 4**: to prove the large-page flag is honoured only at levels 2 and 3.

Each access kind is tried against both kinds of protected entry:
- **Access kinds**: user and supervisor reads and writes.
- **Protected entries**: read-only leaves and supervisor-only intermediate entries.
- **What the results show**: that each permission bit fails at the level that carries it, and that the failing entry is left unwritten.

The memory contents are read back after each walk to tell apart the accessed and dirty updates of leaf and non-leaf entries. A repeat walk over already-flagged entries shows that no redundant writes are issued.

Memory latency is varied, and a request is injected mid-walk, to show the held request and the ignored request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_UPDATE,
        ST_FINISH
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_NONCANON = 2'd1,
        FLT_ABSENT   = 2'd2,
        FLT_PERM     = 2'd3
    } fault_e;

    localparam int ENTRY_W   = 64;
    localparam int VADDR_W   = 64;
    localparam int BIT_VALID = 0;
    localparam int BIT_WR    = 1;
    localparam int BIT_USR   = 2;
    localparam int BIT_ACC   = 5;
    localparam int BIT_DIRTY = 6;
    localparam int BIT_LARGE = 7;

endpackage

// File: rtl/ptw_canon.sv
module ptw_canon #(
    parameter int VA_BITS = 48,
    parameter int ADDR_W  = 64
) (
    input  logic [ADDR_W-1:0] vaddr,
    output logic              canon_ok
);
    localparam int TOP_W = ADDR_W - VA_BITS + 1;

    logic [TOP_W-1:0] upper;

    always_comb begin
        upper    = vaddr[ADDR_W-1:VA_BITS-1];
        canon_ok = (&upper) | (~|upper);
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VA_BITS  = 48,
    parameter int PA_BITS  = 52,
    parameter int IDX_BITS = 9,
    parameter int OFF_BITS = 12,
    parameter int LEVELS   = 4,
    parameter int LVL_W    = 3
) (
    input  logic [PA_BITS-1:0] table_base,
    input  logic [VA_BITS-1:0] vaddr,
    input  logic [LVL_W-1:0]   level,
    output logic [PA_BITS-1:0] entry_addr
);
    localparam int ENT_SH = OFF_BITS - IDX_BITS;

    logic [IDX_BITS-1:0] idx_cand [1:LEVELS];
    logic [IDX_BITS-1:0] idx_sel;

    for (genvar g = 1; g <= LEVELS; g++) begin : g_idx
        localparam int LO = OFF_BITS + IDX_BITS * (LEVELS - g);
        assign idx_cand[g] = vaddr[LO +: IDX_BITS];
    end

    always_comb begin
        idx_sel = '0;
        for (int i = 1; i <= LEVELS; i++) begin
            if (level == LVL_W'(i)) begin
                idx_sel = idx_cand[i];
            end
        end
        entry_addr = {table_base[PA_BITS-1:OFF_BITS], idx_sel, {ENT_SH{1'b0}}};
    end
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter int PA_BITS  = 52,
    parameter int OFF_BITS = 12,
    parameter int LEVELS   = 4,
    parameter int LVL_W    = 3
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [LVL_W-1:0]   level,
    input  logic               acc_write,
    input  logic               acc_user,
    output logic               present,
    output logic               perm_ok,
    output logic               leaf,
    output logic [ENTRY_W-1:0] upd_entry,
    output logic               changed,
    output logic [PA_BITS-1:0] frame_base
);
    logic large_ok;

    always_comb begin
        present  = entry[BIT_VALID];
        perm_ok  = !(acc_user && !entry[BIT_USR]) && !(acc_write && !entry[BIT_WR]);
        large_ok = (level >= LVL_W'(2)) && (level <= LVL_W'(LEVELS - 1));
        leaf     = (level == LVL_W'(LEVELS)) || (large_ok && entry[BIT_LARGE]);

        upd_entry = entry;
        upd_entry[BIT_ACC] = 1'b1;
        if (leaf && acc_write) begin
            upd_entry[BIT_DIRTY] = 1'b1;
        end
        changed = (upd_entry != entry);

        frame_base = {entry[PA_BITS-1:OFF_BITS], {OFF_BITS{1'b0}}};
    end
endmodule

// File: rtl/ptw_pa_form.sv
module ptw_pa_form #(
    parameter int VA_BITS  = 48,
    parameter int PA_BITS  = 52,
    parameter int IDX_BITS = 9,
    parameter int OFF_BITS = 12,
    parameter int LEVELS   = 4,
    parameter int LVL_W    = 3
) (
    input  logic [PA_BITS-1:0] frame_base,
    input  logic [VA_BITS-1:0] vaddr,
    input  logic [LVL_W-1:0]   level,
    output logic [PA_BITS-1:0] paddr
);
    logic [PA_BITS-1:0] va_ext;
    logic [PA_BITS-1:0] pa_cand [1:LEVELS];

    assign va_ext = {{(PA_BITS - VA_BITS){1'b0}}, vaddr};

    for (genvar g = 1; g <= LEVELS; g++) begin : g_leaf
        localparam int SPAN = OFF_BITS + IDX_BITS * (LEVELS - g);
        localparam logic [PA_BITS-1:0] LOW_MASK = {PA_BITS{1'b1}} >> (PA_BITS - SPAN);
        assign pa_cand[g] = (frame_base & ~LOW_MASK) | (va_ext & LOW_MASK);
    end

    always_comb begin
        paddr = '0;
        for (int i = 1; i <= LEVELS; i++) begin
            if (level == LVL_W'(i)) begin
                paddr = pa_cand[i];
            end
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_BITS  = 48,
    parameter int PA_BITS  = 52,
    parameter int IDX_BITS = 9,
    parameter int OFF_BITS = 12,
    parameter int LEVELS   = 4,
    parameter int LVL_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [63:0]         req_vaddr,
    input  logic                req_write,
    input  logic                req_user,
    input  logic [PA_BITS-1:0]  root_base,
    output logic                busy,
    output logic                done,
    output logic [PA_BITS-1:0]  done_paddr,
    output logic [1:0]          done_fault,
    output logic [LVL_W-1:0]    done_level,
    output logic                mem_req,
    output logic                mem_we,
    output logic [PA_BITS-1:0]  mem_addr,
    output logic [63:0]         mem_wdata,
    input  logic                mem_ack,
    input  logic [63:0]         mem_rdata
);
    localparam logic [LVL_W-1:0] FIRST_LVL = LVL_W'(1);

    walk_state_e state_q, state_d;

    logic [VA_BITS-1:0] va_q;
    logic               wr_q;
    logic               user_q;
    logic [LVL_W-1:0]   level_q;
    logic [PA_BITS-1:0] base_q;
    logic [ENTRY_W-1:0] entry_q;
    logic [PA_BITS-1:0] res_pa_q;
    fault_e             res_fault_q;
    logic [LVL_W-1:0]   res_lvl_q;

    logic               canon_ok;
    logic [PA_BITS-1:0] ent_addr;
    logic               ent_present;
    logic               ent_perm_ok;
    logic               ent_leaf;
    logic [ENTRY_W-1:0] ent_upd;
    logic               ent_changed;
    logic [PA_BITS-1:0] ent_frame;
    logic [PA_BITS-1:0] leaf_pa;
    logic               step_ok;

    ptw_canon #(
        .VA_BITS (VA_BITS),
        .ADDR_W  (VADDR_W)
    ) u_canon (
        .vaddr    (req_vaddr),
        .canon_ok (canon_ok)
    );

    ptw_addr_gen #(
        .VA_BITS  (VA_BITS),
        .PA_BITS  (PA_BITS),
        .IDX_BITS (IDX_BITS),
        .OFF_BITS (OFF_BITS),
        .LEVELS   (LEVELS),
        .LVL_W    (LVL_W)
    ) u_addr (
        .table_base (base_q),
        .vaddr      (va_q),
        .level      (level_q),
        .entry_addr (ent_addr)
    );

    ptw_entry_eval #(
        .PA_BITS  (PA_BITS),
        .OFF_BITS (OFF_BITS),
        .LEVELS   (LEVELS),
        .LVL_W    (LVL_W)
    ) u_eval (
        .entry      (entry_q),
        .level      (level_q),
        .acc_write  (wr_q),
        .acc_user   (user_q),
        .present    (ent_present),
        .perm_ok    (ent_perm_ok),
        .leaf       (ent_leaf),
        .upd_entry  (ent_upd),
        .changed    (ent_changed),
        .frame_base (ent_frame)
    );

    ptw_pa_form #(
        .VA_BITS  (VA_BITS),
        .PA_BITS  (PA_BITS),
        .IDX_BITS (IDX_BITS),
        .OFF_BITS (OFF_BITS),
        .LEVELS   (LEVELS),
        .LVL_W    (LVL_W)
    ) u_pa (
        .frame_base (ent_frame),
        .vaddr      (va_q),
        .level      (level_q),
        .paddr      (leaf_pa)
    );

    // An entry has been accepted and its flags are settled in memory.
    assign step_ok = ((state_q == ST_CHECK) && ent_present && ent_perm_ok && !ent_changed)
                   || ((state_q == ST_UPDATE) && mem_ack);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = canon_ok ? ST_FETCH : ST_FINISH;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!ent_present || !ent_perm_ok) begin
                    state_d = ST_FINISH;
                end else if (ent_changed) begin
                    state_d = ST_UPDATE;
                end else if (ent_leaf) begin
                    state_d = ST_FINISH;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_UPDATE: begin
                if (mem_ack) begin
                    state_d = ent_leaf ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q        <= '0;
            wr_q        <= 1'b0;
            user_q      <= 1'b0;
            level_q     <= '0;
            base_q      <= '0;
            entry_q     <= '0;
            res_pa_q    <= '0;
            res_fault_q <= FLT_NONE;
            res_lvl_q   <= '0;
        end else begin
            if ((state_q == ST_IDLE) && req_valid) begin
                va_q    <= req_vaddr[VA_BITS-1:0];
                wr_q    <= req_write;
                user_q  <= req_user;
                base_q  <= {root_base[PA_BITS-1:OFF_BITS], {OFF_BITS{1'b0}}};
                level_q <= canon_ok ? FIRST_LVL : '0;
                if (!canon_ok) begin
                    res_pa_q    <= '0;
                    res_fault_q <= FLT_NONCANON;
                    res_lvl_q   <= '0;
                end
            end

            if ((state_q == ST_FETCH) && mem_ack) begin
                entry_q <= mem_rdata;
            end

            if (state_q == ST_CHECK) begin
                if (!ent_present) begin
                    res_pa_q    <= '0;
                    res_fault_q <= FLT_ABSENT;
                    res_lvl_q   <= level_q;
                end else if (!ent_perm_ok) begin
                    res_pa_q    <= '0;
                    res_fault_q <= FLT_PERM;
                    res_lvl_q   <= level_q;
                end
            end

            if (step_ok) begin
                if (ent_leaf) begin
                    res_pa_q    <= leaf_pa;
                    res_fault_q <= FLT_NONE;
                    res_lvl_q   <= level_q;
                end else begin
                    level_q <= level_q + 1'b1;
                    base_q  <= ent_frame;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FINISH);
        mem_req    = (state_q == ST_FETCH) || (state_q == ST_UPDATE);
        mem_we     = (state_q == ST_UPDATE);
        mem_addr   = ent_addr;
        mem_wdata  = ent_upd;
        done_paddr = res_pa_q;
        done_fault = res_fault_q;
        done_level = res_lvl_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int VA_BITS = 48,
    parameter int PA_BITS = 52,
    parameter int LVL_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [63:0]        req_vaddr,
    input logic               busy,
    input logic               done,
    input logic [PA_BITS-1:0] done_paddr,
    input logic [1:0]         done_fault,
    input logic [LVL_W-1:0]   done_level,
    input logic               mem_req,
    input logic               mem_we,
    input logic [PA_BITS-1:0] mem_addr,
    input logic [63:0]        mem_wdata,
    input logic               mem_ack
);
    logic bad_va;
    assign bad_va = !((&req_vaddr[63:VA_BITS-1]) || !(|req_vaddr[63:VA_BITS-1]));

    assert_canon_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && bad_va) |=> (done && done_fault == 2'd1 && done_level == '0 && !mem_req));

    assert_leaf_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault == 2'd0) |-> (done_level >= LVL_W'(2)));

    assert_writeback_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[5]);

    assert_hold_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_fault_pa_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault != 2'd0) |-> (done_paddr == '0));

    assert_idle_after_reset_R12: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_req));
endmodule

bind ptw_walker ptw_walker_chk #(
    .VA_BITS (VA_BITS),
    .PA_BITS (PA_BITS),
    .LVL_W   (LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .busy       (busy),
    .done       (done),
    .done_paddr (done_paddr),
    .done_fault (done_fault),
    .done_level (done_level),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [51:0] root_base = 52'h10000;
    logic        busy, done, mem_req, mem_we;
    logic [51:0] done_paddr, mem_addr;
    logic [1:0]  done_fault;
    logic [2:0]  done_level;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    int n_checks = 0;
    int n_errors = 0;

    logic [63:0] mem [logic [51:0]];
    int lat = 1;
    int wait_cnt = 0;
    int n_reads = 0;
    int n_writes = 0;
    int n_viol = 0;
    logic        pend = 1'b0;
    logic [51:0] pend_addr = '0;
    logic [63:0] pend_wdata = '0;
    logic        pend_we = 1'b0;

    logic [51:0] r_pa;
    logic [1:0]  r_fault;
    logic [2:0]  r_lvl;

    always #2.5 clk = ~clk;

    ptw_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .root_base(root_base),
        .busy(busy), .done(done), .done_paddr(done_paddr), .done_fault(done_fault),
        .done_level(done_level), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory responder with adjustable latency and a hold-stability monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
            pend     <= 1'b0;
        end else begin
            if (pend && mem_req && (mem_addr !== pend_addr || mem_we !== pend_we
                                    || (mem_we && mem_wdata !== pend_wdata))) begin
                n_viol <= n_viol + 1;
            end
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                pend       <= 1'b1;
                pend_addr  <= mem_addr;
                pend_we    <= mem_we;
                pend_wdata <= mem_wdata;
                if (wait_cnt >= lat) begin
                    mem_ack  <= 1'b1;
                    wait_cnt <= 0;
                    pend     <= 1'b0;
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        n_writes <= n_writes + 1;
                    end else begin
                        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
                        n_reads   <= n_reads + 1;
                    end
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end else begin
                pend <= 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [51:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    task automatic run_walk(input logic [63:0] va, input logic wr, input logic usr);
        logic got;
        got = 1'b0;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 500 && !got; i++) begin
            if (done) begin
                got = 1'b1; r_pa = done_paddr; r_fault = done_fault; r_lvl = done_level;
            end else begin
                @(negedge clk);
            end
        end
        chk("R10 done seen", {63'd0, got}, 64'd1);
        @(negedge clk);
    endtask

    task automatic expect_res(input string tag, input logic [51:0] pa, input logic [1:0] f, input logic [2:0] l);
        chk({tag, " paddr"}, {12'd0, r_pa}, {12'd0, pa});
        chk({tag, " fault"}, {62'd0, r_fault}, {62'd0, f});
        chk({tag, " level"}, {61'd0, r_lvl}, {61'd0, l});
    endtask

    task automatic build_tables;
        mem[52'h10000] = 64'h11007;      // L1[0] -> L2 table
        mem[52'h11000] = 64'h12007;      // L2[0] -> L3 table
        mem[52'h12008] = 64'h13007;      // L3[1] -> L4 table
        mem[52'h13010] = 64'h03005;      // L4[2]: user, read-only
        mem[52'h13018] = 64'h07007;      // L4[3]: user, writable
        mem[52'h12010] = 64'h4000_0087;  // L3[2]: 2 MB leaf
        mem[52'h11008] = 64'h8000_0087;  // L2[1]: 1 GB leaf
        mem[52'h10008] = 64'h14087;      // L1[1]: bit 7 set, must be ignored
        mem[52'h13020] = 64'h06087;      // L4[4]: bit 7 set, must be ignored
        mem[52'h12020] = 64'h15003;      // L3[4]: supervisor-only pointer
        mem[52'h15000] = 64'h09003;      // L4 table 2 [0]
    endtask

    task automatic t_reset;
        chk("R12 busy in reset", {63'd0, busy}, 64'd0);
        chk("R12 done in reset", {63'd0, done}, 64'd0);
        chk("R12 mem_req in reset", {63'd0, mem_req}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R12 idle after reset", {62'd0, busy, mem_req}, 64'd0);
    endtask

    task automatic t_noncanon;
        int ops;
        ops = n_reads + n_writes;
        run_walk(64'h0000_8000_0000_0000, 1'b0, 1'b0);
        expect_res("R1 bit47 set, upper clear", 52'h0, 2'd1, 3'd0);
        run_walk(64'hFFFF_7FFF_FFFF_F000, 1'b0, 1'b1);
        expect_res("R1 upper set, bit47 clear", 52'h0, 2'd1, 3'd0);
        chk("R1 no memory access", 64'(n_reads + n_writes), 64'(ops));
        run_walk(64'hFFFF_8000_0000_0000, 1'b0, 1'b0);
        expect_res("R3 high canonical walks, L1 absent", 52'h0, 2'd2, 3'd1);
    endtask

    task automatic t_small_page;
        int rd0, wr0;
        rd0 = n_reads;
        run_walk(64'h0020_2ABC, 1'b0, 1'b1);
        expect_res("R5 4K user read", 52'h3ABC, 2'd0, 3'd4);
        chk("R2 one read per level", 64'(n_reads - rd0), 64'd4);
        chk("R7 L1 accessed", rd(52'h10000), 64'h11027);
        chk("R7 L2 accessed", rd(52'h11000), 64'h12027);
        chk("R7 L3 accessed", rd(52'h12008), 64'h13027);
        chk("R8 leaf on read no dirty", rd(52'h13010), 64'h03025);
        wr0 = n_writes;
        run_walk(64'h0020_2010, 1'b0, 1'b0);
        expect_res("R4 supervisor read of read-only", 52'h3010, 2'd0, 3'd4);
        chk("R7 no redundant write", 64'(n_writes - wr0), 64'd0);
    endtask

    task automatic t_perm;
        run_walk(64'h0020_2ABC, 1'b1, 1'b1);
        expect_res("R4 user write read-only", 52'h0, 2'd3, 3'd4);
        run_walk(64'h0020_2ABC, 1'b1, 1'b0);
        expect_res("R4 supervisor write read-only", 52'h0, 2'd3, 3'd4);
        chk("R7 faulting leaf untouched", rd(52'h13010), 64'h03025);
        run_walk(64'h0080_0000, 1'b0, 1'b1);
        expect_res("R4 user through supervisor table", 52'h0, 2'd3, 3'd3);
        chk("R7 faulting L3 untouched", rd(52'h12020), 64'h15003);
        run_walk(64'h0080_0044, 1'b0, 1'b0);
        expect_res("R4 supervisor through supervisor table", 52'h9044, 2'd0, 3'd4);
    endtask

    task automatic t_dirty;
        run_walk(64'h0020_3008, 1'b1, 1'b1);
        expect_res("R8 4K user write", 52'h7008, 2'd0, 3'd4);
        chk("R8 leaf dirty", rd(52'h13018), 64'h07067);
        chk("R8 non-leaf clean", rd(52'h12008), 64'h13027);
    endtask

    task automatic t_large;
        run_walk(64'h0041_2345, 1'b0, 1'b1);
        expect_res("R6 2M read", 52'h4001_2345, 2'd0, 3'd3);
        run_walk(64'h0041_2345, 1'b1, 1'b1);
        expect_res("R6 2M write", 52'h4001_2345, 2'd0, 3'd3);
        chk("R8 2M leaf dirty", rd(52'h12010), 64'h4000_00E7);
        run_walk(64'h4123_4567, 1'b0, 1'b1);
        expect_res("R6 1G read", 52'h8123_4567, 2'd0, 3'd2);
        chk("R7 1G leaf accessed", rd(52'h11008), 64'h8000_00A7);
        run_walk(64'h0080_0000_0123, 1'b0, 1'b1);
        expect_res("R6 bit7 at L1 ignored", 52'h0, 2'd2, 3'd2);
        run_walk(64'h0020_4123, 1'b0, 1'b1);
        expect_res("R6 bit7 at L4 ignored", 52'h6123, 2'd0, 3'd4);
    endtask

    task automatic t_absent;
        run_walk(64'h0060_0000, 1'b0, 1'b1);
        expect_res("R3 L3 absent", 52'h0, 2'd2, 3'd3);
    endtask

    task automatic t_busy_ignore;
        int extra;
        lat = 3;
        @(negedge clk);
        req_vaddr = 64'h0020_2ABC; req_write = 1'b0; req_user = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 busy after accept", {63'd0, busy}, 64'd1);
        @(negedge clk);
        req_vaddr = 64'h0001_0000_0000_0000; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 500 && !done; i++) @(negedge clk);
        chk("R11 result kept pa", {12'd0, done_paddr}, 64'h3ABC);
        chk("R11 result kept fault", {62'd0, done_fault}, 64'd0);
        extra = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R11 no extra done", 64'(extra), 64'd0);
        chk("R10 idle after done", {63'd0, busy}, 64'd0);
        run_walk(64'h0020_3008, 1'b1, 1'b1);
        expect_res("R9 slow memory walk", 52'h7008, 2'd0, 3'd4);
        chk("R9 request held stable", 64'(n_viol), 64'd0);
        lat = 0;
        run_walk(64'h4100_0001, 1'b0, 1'b0);
        expect_res("R9 zero-wait memory walk", 52'h8100_0001, 2'd0, 3'd2);
        lat = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        build_tables();
        repeat (3) @(negedge clk);
        t_reset();
        t_noncanon();
        t_small_page();
        t_perm();
        t_dirty();
        t_large();
        t_absent();
        t_busy_ignore();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule